// File: doc/BRIEF.md
# Packed Media and Bit-Count Unit

This block is a 64-bit execution unit for bit-count and packed-data work. One operation is accepted per handshake. Each operation has two operands, A and B, a 7-bit function code and the 5-bit number of the register that supplied A. The unit computes one of these:

- the set-bit, leading-zero or trailing-zero count of B
- the sum of absolute byte differences between A and B
- byte spreading and byte gathering over fixed lane layouts
- lane-wise minimum or maximum over signed or unsigned bytes or 16-bit words
- sign extension of the low byte or low halfword of B

Every result except the sign extensions is zero-extended to the full width. A code the unit does not recognise returns zero and raises an illegal flag.

Operations enter on a valid/ready port and leave on a valid/ready port. The output stage is a single register. An operation accepted at a clock edge appears on the output port right after that edge. It stays there, unchanged, until a cycle in which `out_ready` is high. The input accepts a new operation whenever the output register is empty or is being drained in the same cycle. That is, `in_ready` is high when `out_valid` is low or `out_ready` is high. When the output is full and not drained, `in_ready` is low and the upstream side must hold its operation. Throughput is one operation per cycle while the consumer keeps `out_ready` high.

Top module: `pmb_unit`

## Requirements
- R1: `in_ready` equals (not `out_valid`) or `out_ready`. An operation accepted at a rising edge (`in_valid` and `in_ready` both high) is presented with `out_valid` high right after that edge. Results leave in acceptance order. With nothing accepted and the output drained, `out_valid` goes low.
- R2: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_result` and `out_illegal` hold their values.
- R3: Code 0x00 returns B[7:0] sign-extended to 64 bits. Code 0x01 returns B[15:0] sign-extended. Both are legal only when `in_ra_sel` is 31. With any other value they return zero with the illegal flag set.
- R4: Code 0x30 returns the number of 1 bits in B.
- R5: Code 0x32 returns the count of leading zeros of B and code 0x33 the count of trailing zeros. Each returns 64 for B equal to zero.
- R6: Code 0x31 returns the sum, over the eight byte lanes, of |A byte − B byte| with the bytes taken as unsigned.
- R7: Code 0x34 places B byte k (k = 0..3) at result bits [16k+7:16k]. Code 0x35 places B byte k (k = 0..1) at result bits [32k+7:32k]. All other result bits are zero.
- R8: Code 0x36 collects B bits [16k+7:16k] into result byte k (k = 0..3). Code 0x37 collects B bits [32k+7:32k] into result byte k (k = 0..1). All other result bits are zero.
- R9: Lane-wise minimum of A and B: code 0x38 over signed bytes, 0x3a over unsigned bytes, 0x39 over signed 16-bit words, 0x3b over unsigned 16-bit words.
- R10: Lane-wise maximum of A and B: code 0x3e over signed bytes, 0x3c over unsigned bytes, 0x3f over signed 16-bit words, 0x3d over unsigned 16-bit words.
- R11: Any code not listed in R3 to R10 returns a zero result with `out_illegal` high. The listed codes return `out_illegal` low, except for the R3 case with the wrong register number.
- R12: During and right after reset (`rst_n` low), `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken this cycle |
| in_func | input | 7 | Function code |
| in_ra_sel | input | 5 | Register number that supplied A |
| in_a | input | 64 | Operand A |
| in_b | input | 64 | Operand B |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | 64 | Result |
| out_illegal | output | 1 | Code was not recognised, or its register-number condition failed |

## Verification
The assertions watch the port protocol on every cycle:

- an accepted operation always yields a valid output on the next cycle
- a stalled result holds all of its fields
- a drained, unrefilled output goes empty
- an illegal result is always zero
- leading, trailing and set-bit counts of a nonzero operand are consistent with one another

The arithmetic itself can only be shown by the bench's scenarios. These include:

- all-zero and all-one operands for the counts
- lanes that differ only in sign, for signed versus unsigned min and max
- exact lane placement for spreading and gathering
- the register-number condition on sign extension
- unknown codes

Ordering under random back-pressure is also only shown by the bench.

// File: rtl/pmb_pkg.sv
package pmb_pkg;

  localparam int FUNC_W = 7;

  typedef enum logic [FUNC_W-1:0] {
    FN_SEXT_BYTE  = 7'h00,
    FN_SEXT_HALF  = 7'h01,
    FN_POPCNT     = 7'h30,
    FN_ABSDIFF    = 7'h31,
    FN_LEAD_ZERO  = 7'h32,
    FN_TRAIL_ZERO = 7'h33,
    FN_SPREAD_W   = 7'h34,
    FN_SPREAD_L   = 7'h35,
    FN_GATHER_W   = 7'h36,
    FN_GATHER_L   = 7'h37,
    FN_MIN_SB     = 7'h38,
    FN_MIN_SW     = 7'h39,
    FN_MIN_UB     = 7'h3a,
    FN_MIN_UW     = 7'h3b,
    FN_MAX_UB     = 7'h3c,
    FN_MAX_UW     = 7'h3d,
    FN_MAX_SB     = 7'h3e,
    FN_MAX_SW     = 7'h3f
  } pmb_func_e;

endpackage

// File: rtl/pmb_bitcount.sv
module pmb_bitcount #(
  parameter int DATA_W = 64,
  parameter int CNT_W  = $clog2(DATA_W + 1)
) (
  input  logic [DATA_W-1:0] src,
  output logic [CNT_W-1:0]  ones,
  output logic [CNT_W-1:0]  lead,
  output logic [CNT_W-1:0]  trail
);

  always_comb begin
    ones = '0;
    for (int i = 0; i < DATA_W; i++) begin
      ones = ones + CNT_W'(src[i]);
    end
  end

  // Scan from the top; the first 1 found fixes the count.
  always_comb begin
    logic hit;
    hit  = 1'b0;
    lead = CNT_W'(DATA_W);
    for (int i = DATA_W - 1; i >= 0; i--) begin
      if (!hit && src[i]) begin
        lead = CNT_W'(DATA_W - 1 - i);
        hit  = 1'b1;
      end
    end
  end

  // Scan from the bottom.
  always_comb begin
    logic hit;
    hit   = 1'b0;
    trail = CNT_W'(DATA_W);
    for (int i = 0; i < DATA_W; i++) begin
      if (!hit && src[i]) begin
        trail = CNT_W'(i);
        hit   = 1'b1;
      end
    end
  end

  // For a nonzero word the leading zeros, trailing zeros and ones never overlap.
  always_comb begin
    if (src != '0) begin
      AST_COUNT_CONSISTENT: assert (int'(lead) + int'(trail) + int'(ones) <= DATA_W)
        else $error("bit counts inconsistent"); // R5
    end
  end

endmodule

// File: rtl/pmb_pack.sv
module pmb_pack #(
  parameter int DATA_W = 64,
  parameter int SAD_W  = $clog2((DATA_W / 8) * 255 + 1)
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] spread_w,
  output logic [DATA_W-1:0] spread_l,
  output logic [DATA_W-1:0] gather_w,
  output logic [DATA_W-1:0] gather_l,
  output logic [DATA_W-1:0] absdiff
);

  localparam int BYTES = DATA_W / 8;
  localparam int HALFS = DATA_W / 16;
  localparam int WORDS = DATA_W / 32;

  logic [SAD_W-1:0] sad_sum;
  logic [7:0]       lane_diff [BYTES];

  // One absolute difference per byte lane.
  genvar g;
  generate
    for (g = 0; g < BYTES; g++) begin : g_diff
      logic [7:0] ab;
      logic [7:0] bb;
      assign ab = a[8*g +: 8];
      assign bb = b[8*g +: 8];
      assign lane_diff[g] = (ab >= bb) ? (ab - bb) : (bb - ab);
    end
  endgenerate

  always_comb begin
    sad_sum = '0;
    for (int i = 0; i < BYTES; i++) begin
      sad_sum = sad_sum + SAD_W'(lane_diff[i]);
    end
  end

  assign absdiff = DATA_W'(sad_sum);

  // Spread low bytes out to the start of each halfword or word lane,
  // and gather them back.
  always_comb begin
    spread_w = '0;
    spread_l = '0;
    gather_w = '0;
    gather_l = '0;
    for (int k = 0; k < HALFS; k++) begin
      spread_w[16*k +: 8] = b[8*k +: 8];
      gather_w[8*k +: 8]  = b[16*k +: 8];
    end
    for (int k = 0; k < WORDS; k++) begin
      spread_l[32*k +: 8] = b[8*k +: 8];
      gather_l[8*k +: 8]  = b[32*k +: 8];
    end
  end

endmodule

// File: rtl/pmb_lane_minmax.sv
module pmb_lane_minmax #(
  parameter int DATA_W = 64,
  parameter int LANE_W = 8
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              is_signed,
  input  logic              take_max,
  output logic [DATA_W-1:0] y
);

  localparam int LANES = DATA_W / LANE_W;

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] la;
      logic [LANE_W-1:0] lb;
      logic              a_gt;
      logic              a_lt;
      assign la   = a[LANE_W*g +: LANE_W];
      assign lb   = b[LANE_W*g +: LANE_W];
      assign a_gt = is_signed ? ($signed(la) > $signed(lb)) : (la > lb);
      assign a_lt = is_signed ? ($signed(la) < $signed(lb)) : (la < lb);
      assign y[LANE_W*g +: LANE_W] = take_max ? (a_gt ? la : lb) : (a_lt ? la : lb);
    end
  endgenerate

endmodule

// File: rtl/pmb_unit.sv
module pmb_unit
  import pmb_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int REG_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [FUNC_W-1:0] in_func,
  input  logic [REG_W-1:0]  in_ra_sel,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_result,
  output logic              out_illegal
);

  localparam int              CNT_W    = $clog2(DATA_W + 1);
  localparam logic [REG_W-1:0] ZERO_REG = {REG_W{1'b1}};

  logic [CNT_W-1:0]  cnt_ones, cnt_lead, cnt_trail;
  logic [DATA_W-1:0] spread_w, spread_l, gather_w, gather_l, absdiff;
  logic [DATA_W-1:0] mm_byte, mm_half;
  logic              mm_signed, mm_max;
  logic [DATA_W-1:0] nxt_result;
  logic              nxt_illegal;
  logic              accept;

  pmb_bitcount #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_count (
    .src   (in_b),
    .ones  (cnt_ones),
    .lead  (cnt_lead),
    .trail (cnt_trail)
  );

  pmb_pack #(.DATA_W(DATA_W)) u_pack (
    .a        (in_a),
    .b        (in_b),
    .spread_w (spread_w),
    .spread_l (spread_l),
    .gather_w (gather_w),
    .gather_l (gather_l),
    .absdiff  (absdiff)
  );

  // Code bit 1 picks signed lanes for minimum (0x38/0x39); for maximum the
  // signed pair is 0x3e/0x3f. Code bit 2 picks maximum.
  assign mm_max    = in_func[2];
  assign mm_signed = mm_max ? in_func[1] : ~in_func[1];

  pmb_lane_minmax #(.DATA_W(DATA_W), .LANE_W(8)) u_mm_byte (
    .a         (in_a),
    .b         (in_b),
    .is_signed (mm_signed),
    .take_max  (mm_max),
    .y         (mm_byte)
  );

  pmb_lane_minmax #(.DATA_W(DATA_W), .LANE_W(16)) u_mm_half (
    .a         (in_a),
    .b         (in_b),
    .is_signed (mm_signed),
    .take_max  (mm_max),
    .y         (mm_half)
  );

  always_comb begin
    nxt_result  = '0;
    nxt_illegal = 1'b0;
    case (in_func)
      FN_SEXT_BYTE: begin
        if (in_ra_sel == ZERO_REG) nxt_result = {{(DATA_W-8){in_b[7]}}, in_b[7:0]};
        else                       nxt_illegal = 1'b1;
      end
      FN_SEXT_HALF: begin
        if (in_ra_sel == ZERO_REG) nxt_result = {{(DATA_W-16){in_b[15]}}, in_b[15:0]};
        else                       nxt_illegal = 1'b1;
      end
      FN_POPCNT:     nxt_result = DATA_W'(cnt_ones);
      FN_LEAD_ZERO:  nxt_result = DATA_W'(cnt_lead);
      FN_TRAIL_ZERO: nxt_result = DATA_W'(cnt_trail);
      FN_ABSDIFF:    nxt_result = absdiff;
      FN_SPREAD_W:   nxt_result = spread_w;
      FN_SPREAD_L:   nxt_result = spread_l;
      FN_GATHER_W:   nxt_result = gather_w;
      FN_GATHER_L:   nxt_result = gather_l;
      FN_MIN_SB, FN_MIN_UB, FN_MAX_UB, FN_MAX_SB: nxt_result = mm_byte;
      FN_MIN_SW, FN_MIN_UW, FN_MAX_UW, FN_MAX_SW: nxt_result = mm_half;
      default:       nxt_illegal = 1'b1;
    endcase
  end

  // Single output register: refill allowed when empty or draining.
  assign in_ready = ~out_valid | out_ready;
  assign accept   = in_valid & in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_illegal <= 1'b0;
    end else if (accept) begin
      out_valid   <= 1'b1;
      out_result  <= nxt_result;
      out_illegal <= nxt_illegal;
    end else if (out_ready) begin
      out_valid   <= 1'b0;
    end
  end

  AST_ACCEPT_TO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid); // R1

  AST_DRAIN_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid); // R1

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_illegal))); // R2

  AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_illegal) |-> (out_result == '0)); // R11

endmodule

// File: tb/test_pmb_unit.sv
`timescale 1ns/1ps
module test_pmb_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [6:0]  in_func = '0;
  logic [4:0]  in_ra_sel = '0;
  logic [63:0] in_a = '0;
  logic [63:0] in_b = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_result;
  logic        out_illegal;

  int checks = 0;
  int errors = 0;
  bit bp_mode = 1'b0;
  bit done = 1'b0;

  logic [64:0] exp_q [$];
  string       tag_q [$];

  always #2.5 clk = ~clk;

  pmb_unit i_pmb_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_func(in_func), .in_ra_sel(in_ra_sel), .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_illegal(out_illegal)
  );

  // Reference model, written from the requirements
  function automatic longint lane_val(logic [63:0] v, int i, int w, bit sgn);
    longint x;
    x = longint'((v >> (i * w)) & ((64'd1 << w) - 1));
    if (sgn && x[w-1]) x = x - (longint'(1) << w);
    return x;
  endfunction

  function automatic logic [63:0] ref_minmax(logic [63:0] a, logic [63:0] b,
                                             int w, bit sgn, bit mx);
    logic [63:0] r;
    r = '0;
    for (int i = 0; i < 64 / w; i++) begin
      longint xa, xb;
      logic [63:0] pick;
      xa = lane_val(a, i, w, sgn);
      xb = lane_val(b, i, w, sgn);
      pick = (mx ? (xa > xb) : (xa < xb)) ? a : b;
      r = r | (((pick >> (i * w)) & ((64'd1 << w) - 1)) << (i * w));
    end
    return r;
  endfunction

  function automatic logic [64:0] ref_op(logic [6:0] f, logic [4:0] ra,
                                         logic [63:0] a, logic [63:0] b);
    logic [63:0] r;
    bit ill;
    int n;
    r = '0;
    ill = 1'b0;
    case (f)
      7'h00: if (ra == 5'd31) r = {{56{b[7]}}, b[7:0]}; else ill = 1'b1;
      7'h01: if (ra == 5'd31) r = {{48{b[15]}}, b[15:0]}; else ill = 1'b1;
      7'h30: begin
        n = 0;
        for (int i = 0; i < 64; i++) n += int'(b[i]);
        r = 64'(n);
      end
      7'h31: begin
        n = 0;
        for (int i = 0; i < 8; i++) begin
          int x, y;
          x = int'(b[8*i +: 8]);
          y = int'(a[8*i +: 8]);
          n += (x > y) ? x - y : y - x;
        end
        r = 64'(n);
      end
      7'h32: begin
        n = 0;
        while (n < 64 && !b[63 - n]) n++;
        r = 64'(n);
      end
      7'h33: begin
        n = 0;
        while (n < 64 && !b[n]) n++;
        r = 64'(n);
      end
      7'h34: r = {8'h0, b[31:24], 8'h0, b[23:16], 8'h0, b[15:8], 8'h0, b[7:0]};
      7'h35: r = {24'h0, b[15:8], 24'h0, b[7:0]};
      7'h36: r = {32'h0, b[55:48], b[39:32], b[23:16], b[7:0]};
      7'h37: r = {48'h0, b[39:32], b[7:0]};
      7'h38: r = ref_minmax(a, b, 8, 1, 0);
      7'h3a: r = ref_minmax(a, b, 8, 0, 0);
      7'h39: r = ref_minmax(a, b, 16, 1, 0);
      7'h3b: r = ref_minmax(a, b, 16, 0, 0);
      7'h3e: r = ref_minmax(a, b, 8, 1, 1);
      7'h3c: r = ref_minmax(a, b, 8, 0, 1);
      7'h3f: r = ref_minmax(a, b, 16, 1, 1);
      7'h3d: r = ref_minmax(a, b, 16, 0, 1);
      default: ill = 1'b1;
    endcase
    return {ill, r};
  endfunction

  task automatic check(bit ok, string tag, logic [64:0] act, logic [64:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: offer at a falling edge, hold until in_ready is seen high.
  task automatic send(logic [6:0] f, logic [4:0] ra, logic [63:0] a,
                      logic [63:0] b, string tag);
    @(negedge clk);
    in_valid = 1'b1; in_func = f; in_ra_sel = ra; in_a = a; in_b = b;
    while (!in_ready) @(negedge clk);
    exp_q.push_back(ref_op(f, ra, a, b));
    tag_q.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Consumer side: ready changes only just after a rising edge.
  always @(posedge clk) begin
    #1;
    out_ready = bp_mode ? (($urandom % 3) != 0) : 1'b1;
  end

  // Monitor / scoreboard
  bit          prev_stall = 1'b0;
  logic [64:0] prev_out;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (prev_stall) begin
        // R2: a stalled result must still be there, unchanged
        check(out_valid && {out_illegal, out_result} == prev_out, "R2",
              {out_illegal, out_result}, prev_out);
      end
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R1 unexpected output", {out_illegal, out_result}, '0);
        end else begin
          logic [64:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check({out_illegal, out_result} == e, t, {out_illegal, out_result}, e);
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_out   = {out_illegal, out_result};
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  function automatic logic [63:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  initial begin
    logic [6:0] codes [18];
    codes = '{7'h00, 7'h01, 7'h30, 7'h31, 7'h32, 7'h33, 7'h34, 7'h35, 7'h36,
              7'h37, 7'h38, 7'h39, 7'h3a, 7'h3b, 7'h3c, 7'h3d, 7'h3e, 7'h3f};
    void'($urandom(32'h5eed));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R12: output empty while held in reset
    check(out_valid == 1'b0, "R12 in reset", 65'(out_valid), '0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R12 after reset", 65'(out_valid), '0);
    check(in_ready == 1'b1, "R1 ready when empty", 65'(in_ready), 65'(1));

    // R3 sign extension, legal and with the wrong register number
    send(7'h00, 5'd31, '0, 64'h1234_5678_9abc_de80, "R3 byte neg");
    send(7'h00, 5'd31, '0, 64'hffff_ffff_ffff_ff7f, "R3 byte pos");
    send(7'h01, 5'd31, '0, 64'h0000_0000_0000_8001, "R3 half neg");
    send(7'h01, 5'd31, '0, 64'hffff_ffff_ffff_7fff, "R3 half pos");
    send(7'h00, 5'd4,  '0, 64'h80, "R3 byte bad reg");
    send(7'h01, 5'd30, '0, 64'h8000, "R3 half bad reg");
    // R4 / R5 counts with corner operands
    send(7'h30, 5'd0, '0, '0, "R4 zero");
    send(7'h30, 5'd0, '0, '1, "R4 ones");
    send(7'h32, 5'd0, '0, '0, "R5 clz zero");
    send(7'h33, 5'd0, '0, '0, "R5 ctz zero");
    send(7'h32, 5'd0, '0, 64'h8000_0000_0000_0000, "R5 clz top");
    send(7'h33, 5'd0, '0, 64'h8000_0000_0000_0000, "R5 ctz top");
    send(7'h32, 5'd0, '0, 64'h1, "R5 clz bottom");
    send(7'h33, 5'd0, '0, 64'h1, "R5 ctz bottom");
    // R6 absolute differences in both directions
    send(7'h31, 5'd0, 64'hff00_ff00_0102_0304, 64'h00ff_00ff_0403_0201, "R6 mixed");
    send(7'h31, 5'd0, '1, '0, "R6 max");
    // R7 / R8 lane placement
    send(7'h34, 5'd0, '0, 64'hdead_beef_1122_3344, "R7 spread halfwords");
    send(7'h35, 5'd0, '0, 64'hdead_beef_1122_3344, "R7 spread words");
    send(7'h36, 5'd0, '0, 64'h0102_0304_0506_0708, "R8 gather halfwords");
    send(7'h37, 5'd0, '0, 64'h0102_0304_0506_0708, "R8 gather words");
    // R9 / R10 lanes differing only in sign
    send(7'h38, 5'd0, 64'h80_7f_00_ff_01_fe_40_c0, 64'h7f_80_ff_00_fe_01_c0_40, "R9 min sb");
    send(7'h3a, 5'd0, 64'h80_7f_00_ff_01_fe_40_c0, 64'h7f_80_ff_00_fe_01_c0_40, "R9 min ub");
    send(7'h39, 5'd0, 64'h8000_7fff_0001_ffff, 64'h7fff_8000_ffff_0001, "R9 min sw");
    send(7'h3b, 5'd0, 64'h8000_7fff_0001_ffff, 64'h7fff_8000_ffff_0001, "R9 min uw");
    send(7'h3e, 5'd0, 64'h80_7f_00_ff_01_fe_40_c0, 64'h7f_80_ff_00_fe_01_c0_40, "R10 max sb");
    send(7'h3c, 5'd0, 64'h80_7f_00_ff_01_fe_40_c0, 64'h7f_80_ff_00_fe_01_c0_40, "R10 max ub");
    send(7'h3f, 5'd0, 64'h8000_7fff_0001_ffff, 64'h7fff_8000_ffff_0001, "R10 max sw");
    send(7'h3d, 5'd0, 64'h8000_7fff_0001_ffff, 64'h7fff_8000_ffff_0001, "R10 max uw");
    // R11 unknown codes
    send(7'h02, 5'd31, '1, '1, "R11 code 02");
    send(7'h2f, 5'd31, '1, '1, "R11 code 2f");
    send(7'h40, 5'd31, '1, '1, "R11 code 40");
    send(7'h7f, 5'd31, '1, '1, "R11 code 7f");
    idle();
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1 empty after drain", 65'(out_valid), '0);

    // R1 / R2: random traffic under back-pressure, with gaps
    bp_mode = 1'b1;
    for (int n = 0; n < 400; n++) begin
      logic [6:0] f;
      f = (($urandom % 8) == 0) ? 7'($urandom) : codes[$urandom % 18];
      send(f, (($urandom % 2) == 0) ? 5'd31 : 5'($urandom), rnd64(), rnd64(),
           "R1 random stream");
      if (($urandom % 5) == 0) idle();
    end
    idle();
    bp_mode = 1'b0;
    repeat (10) @(negedge clk);
    check(exp_q.size() == 0, "R1 all results delivered", 65'(exp_q.size()), '0);
    finish_run();
  end

endmodule